// File: doc/BRIEF.md
# Flash Command Launch Status Controller

This block holds the byte-wide status register of an embedded flash controller and sequences command launches toward the flash array. Software reads four live flags: buffer-empty, command-complete, protection-violation and access-error. It starts a command by writing 1 to the buffer-empty flag, and it clears an error flag by writing 1 to it. The opcode of the command being launched is presented on `cmd_opcode` together with qualifiers from the surrounding controller: whether the command sequence was followed, whether the clock divider is initialised, and whether the target lies in a protected region.

An accepted command waits in a one-deep buffer. It moves to the array as a one-cycle start pulse that carries the opcode, and the array answers with a one-cycle done pulse. Only burst-program commands may be queued behind a running burst. Any command that breaks a rule is dropped without reaching the array, and the matching error flag is raised. Entering stop mode while work is pending flushes that work, raises an abort pulse toward the array and flags an access error.

Top module: `flash_launch_ctrl`

## Requirements
- R1: After reset the status reads 0xC0. Bits 3, 2, 1 and 0 always read 0, and writes to them change nothing.
- R2: Writing a value with bit 7 set while bit 7 reads 1 is a launch. When the launch is legal (sequence valid, divider ready, target unprotected, array free), bits 7 and 6 read 0 after that write edge. At the next edge `arr_start` pulses for one cycle with the launched opcode on `arr_op`, and bit 7 reads 1 again.
- R3: Bit 6 (complete) reads 1 exactly when the buffer is empty and the array is idle. It returns to 1 after the array's done pulse, and writes to bit 6 have no effect.
- R4: While a burst-program command (opcode `BURST_OP`) executes and bit 7 reads 1, a further burst launch is accepted. It starts in the cycle after the edge that samples `arr_done`.
- R5: A launch is an ordering error and sets bit 4 (access error) when the array is busy and either the new command or the running command is not a burst. The command is discarded and bit 7 stays 1.
- R6: A launch with `seq_ok` low sets bit 4 and is discarded. Bits 7 and 6 both read 1 right after the write when nothing else is pending.
- R7: A launch with `div_ready` low sets bit 4 and is discarded.
- R8: A launch with `tgt_prot` high and no access-error cause sets bit 5 (protection violation) and is discarded. When an access-error cause is present too, only bit 4 is set.
- R9: A `stop_req` while a command is buffered or executing sets bit 4, empties the buffer, idles the array and pulses `arr_abort` for one cycle, so the status reads 0xD0. A `stop_req` while idle does nothing.
- R10: Writing 1 to bit 5 or bit 4 clears that flag. Writing 0 to it leaves it unchanged.
- R11: A launch is ignored, with no flag change and no start, when bit 5 or bit 4 would still be set after the clears in the same write. A write that clears all set errors and launches is accepted.
- R12: Writing 1 to bit 7 while it reads 0 is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read value |
| cmd_opcode | input | CMD_W | Opcode of the command being launched |
| seq_ok | input | 1 | Command sequence was followed correctly |
| div_ready | input | 1 | Flash clock divider has been initialised |
| tgt_prot | input | 1 | Target address lies in a protected block |
| stop_req | input | 1 | Stop-mode entry request |
| arr_start | output | 1 | One-cycle command start to the array |
| arr_op | output | CMD_W | Opcode accompanying `arr_start` |
| arr_abort | output | 1 | One-cycle abort to the array on stop entry |
| arr_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The assertions rely on the array raising `arr_done` only while it is executing a started command, never in the cycle of its own start pulse, and on the qualifiers `seq_ok`, `div_ready` and `tgt_prot` being stable in any write cycle. The bench array model counts a fixed busy time from each start, drops its count on abort, and pulses done once per start. The bench changes qualifiers and `cmd_opcode` only on falling edges, one full cycle before the write that uses them.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_EMPTY = 7;
  localparam int unsigned BIT_DONE  = 6;
  localparam int unsigned BIT_PROT  = 5;
  localparam int unsigned BIT_ACC   = 4;
  localparam int unsigned BIT_BLANK = 2;

  typedef struct packed {
    logic accept;
    logic set_prot;
    logic set_acc;
  } launch_res_t;
endpackage

// File: rtl/flc_launch_check.sv
module flc_launch_check
  import flc_pkg::*;
(
  input  logic        wr_en,
  input  logic        w_launch,
  input  logic        w_clr_prot,
  input  logic        w_clr_acc,
  input  logic        buf_empty,
  input  logic        prot_q,
  input  logic        acc_q,
  input  logic        seq_ok,
  input  logic        div_ready,
  input  logic        tgt_prot,
  input  logic        is_burst,
  input  logic        arr_busy,
  input  logic        busy_burst,
  input  logic        stop_hit,
  output launch_res_t res
);
  logic launch_req;
  logic prot_left;
  logic acc_left;
  logic gate_ok;
  logic order_bad;
  logic acc_bad;

  always_comb begin
    launch_req = wr_en & w_launch & buf_empty & ~stop_hit;
    prot_left  = prot_q & ~(wr_en & w_clr_prot);
    acc_left   = acc_q & ~(wr_en & w_clr_acc);
    gate_ok    = launch_req & ~prot_left & ~acc_left;
    order_bad  = arr_busy & (~is_burst | ~busy_burst);
    acc_bad    = ~seq_ok | ~div_ready | order_bad;
    res.set_acc  = gate_ok & acc_bad;
    res.set_prot = gate_ok & ~acc_bad & tgt_prot;
    res.accept   = gate_ok & ~acc_bad & ~tgt_prot;
  end
endmodule

// File: rtl/flc_status_flags.sv
module flc_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic w_clr_prot,
  input  logic w_clr_acc,
  input  logic set_prot,
  input  logic set_acc,
  output logic prot_q,
  output logic acc_q
);
  logic prot_d;
  logic acc_d;
  logic upd_en;

  always_comb begin
    upd_en = wr_en | set_prot | set_acc;
    prot_d = (prot_q & ~(wr_en & w_clr_prot)) | set_prot;
    acc_d  = (acc_q & ~(wr_en & w_clr_acc)) | set_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (upd_en) begin
      prot_q <= prot_d;
      acc_q  <= acc_d;
    end
  end

  // R10
  acc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_clr_acc && !set_acc) |=> !acc_q);
  // R10
  prot_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_clr_prot && !set_prot) |=> !prot_q);
  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !wr_en) |=> acc_q);
endmodule

// File: rtl/flc_cmd_buffer.sv
module flc_cmd_buffer #(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CMD_W-1:0] cmd_op,
  input  logic             cmd_burst,
  input  logic             stop_req,
  input  logic             arr_done,
  output logic             buf_full_q,
  output logic             busy_q,
  output logic             busy_burst_q,
  output logic             stop_hit,
  output logic             arr_start,
  output logic [CMD_W-1:0] arr_op,
  output logic             arr_abort
);
  logic [CMD_W-1:0] buf_op_q;
  logic             buf_burst_q;
  logic             xfer;
  logic             buf_full_d;
  logic             busy_d;

  always_comb begin
    stop_hit = stop_req & (buf_full_q | busy_q);
    xfer     = buf_full_q & (~busy_q | arr_done) & ~stop_hit;
    if (stop_hit)    buf_full_d = 1'b0;
    else if (accept) buf_full_d = 1'b1;
    else if (xfer)   buf_full_d = 1'b0;
    else             buf_full_d = buf_full_q;
    if (stop_hit)               busy_d = 1'b0;
    else if (xfer)              busy_d = 1'b1;
    else if (busy_q && arr_done) busy_d = 1'b0;
    else                        busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full_q <= 1'b0;
      busy_q     <= 1'b0;
      arr_start  <= 1'b0;
      arr_abort  <= 1'b0;
    end else begin
      buf_full_q <= buf_full_d;
      busy_q     <= busy_d;
      arr_start  <= xfer;
      arr_abort  <= stop_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_op_q    <= '0;
      buf_burst_q <= 1'b0;
    end else if (accept) begin
      buf_op_q    <= cmd_op;
      buf_burst_q <= cmd_burst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_op       <= '0;
      busy_burst_q <= 1'b0;
    end else if (xfer) begin
      arr_op       <= buf_op_q;
      busy_burst_q <= buf_burst_q;
    end
  end

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(buf_full_q));
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !arr_done && !stop_hit) |=> !arr_start);
  // R9
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (!buf_full_q && !busy_q && arr_abort));
endmodule

// File: rtl/flash_launch_ctrl.sv
module flash_launch_ctrl
  import flc_pkg::*;
#(
  parameter int unsigned    CMD_W    = 8,
  parameter logic [CMD_W-1:0] BURST_OP = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic [CMD_W-1:0]  cmd_opcode,
  input  logic              seq_ok,
  input  logic              div_ready,
  input  logic              tgt_prot,
  input  logic              stop_req,
  output logic              arr_start,
  output logic [CMD_W-1:0]  arr_op,
  output logic              arr_abort,
  input  logic              arr_done
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        buf_full;
  logic        arr_busy;
  logic        busy_burst;
  logic        stop_hit;
  logic        prot_q;
  logic        acc_q;
  logic        is_burst;
  logic        buf_empty;
  logic        cmd_done;
  launch_res_t res;
  logic        unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign is_burst     = (cmd_opcode == BURST_OP);
  assign buf_empty    = ~buf_full;
  assign cmd_done     = ~buf_full & ~arr_busy;
  assign unused_wbits = ^{reg_wdata[BIT_DONE], reg_wdata[3:0]};

  flc_launch_check u_check (
    .wr_en      (reg_wr),
    .w_launch   (reg_wdata[BIT_EMPTY]),
    .w_clr_prot (reg_wdata[BIT_PROT]),
    .w_clr_acc  (reg_wdata[BIT_ACC]),
    .buf_empty  (buf_empty),
    .prot_q     (prot_q),
    .acc_q      (acc_q),
    .seq_ok     (seq_ok),
    .div_ready  (div_ready),
    .tgt_prot   (tgt_prot),
    .is_burst   (is_burst),
    .arr_busy   (arr_busy),
    .busy_burst (busy_burst),
    .stop_hit   (stop_hit),
    .res        (res)
  );

  flc_status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (reg_wr),
    .w_clr_prot (reg_wdata[BIT_PROT]),
    .w_clr_acc  (reg_wdata[BIT_ACC]),
    .set_prot   (res.set_prot),
    .set_acc    (res.set_acc | stop_hit),
    .prot_q     (prot_q),
    .acc_q      (acc_q)
  );

  flc_cmd_buffer #(.CMD_W(CMD_W)) u_buf (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .accept       (res.accept),
    .cmd_op       (cmd_opcode),
    .cmd_burst    (is_burst),
    .stop_req     (stop_req),
    .arr_done     (arr_done),
    .buf_full_q   (buf_full),
    .busy_q       (arr_busy),
    .busy_burst_q (busy_burst),
    .stop_hit     (stop_hit),
    .arr_start    (arr_start),
    .arr_op       (arr_op),
    .arr_abort    (arr_abort)
  );

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_EMPTY] = buf_empty;
    reg_rdata[BIT_DONE]  = cmd_done;
    reg_rdata[BIT_PROT]  = prot_q;
    reg_rdata[BIT_ACC]   = acc_q;
    reg_rdata[BIT_BLANK] = 1'b0;
  end

  // R3
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_rdata[BIT_DONE] |-> reg_rdata[BIT_EMPTY]);
  // R12
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && !reg_rdata[BIT_EMPTY] && !stop_req && !reg_rdata[BIT_ACC])
      |=> !reg_rdata[BIT_ACC]);
endmodule

// File: tb/flash_launch_ctrl_tb_top.sv
module flash_launch_ctrl_tb_top;
  localparam int unsigned CMD_W = 8;
  localparam logic [7:0] OP_BURST = 8'h25;
  localparam logic [7:0] OP_PLAIN = 8'h20;
  localparam int BUSY_CYC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [CMD_W-1:0] cmd_opcode;
  logic seq_ok, div_ready, tgt_prot, stop_req;
  logic arr_start, arr_abort;
  logic [CMD_W-1:0] arr_op;
  logic arr_done;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  flash_launch_ctrl #(.CMD_W(CMD_W), .BURST_OP(OP_BURST)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_opcode(cmd_opcode), .seq_ok(seq_ok),
    .div_ready(div_ready), .tgt_prot(tgt_prot), .stop_req(stop_req),
    .arr_start(arr_start), .arr_op(arr_op), .arr_abort(arr_abort),
    .arr_done(arr_done)
  );

  // array model: fixed busy time per start, drops work on abort
  int  cnt;
  bit  active;
  always @(posedge clk) begin
    if (!rst_n) begin
      active   <= 0;
      cnt      <= 0;
      arr_done <= 1'b0;
    end else if (arr_abort) begin
      active   <= 0;
      arr_done <= 1'b0;
    end else if (arr_start) begin
      active   <= 1;
      cnt      <= BUSY_CYC;
      arr_done <= 1'b0;
    end else if (active) begin
      if (cnt == 1) begin
        arr_done <= 1'b1;
        active   <= 0;
      end else begin
        cnt      <= cnt - 1;
        arr_done <= 1'b0;
      end
    end else begin
      arr_done <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every start must match the next expected opcode
  always @(negedge clk) begin
    if (rst_n && arr_start) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fails++;
        $display("FAIL R12: actual start op 0x%02h expected no start", arr_op);
      end else begin
        check("R2 start opcode", arr_op, exp_q.pop_front());
      end
    end
  end

  task automatic wr_reg(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic launch(input logic [7:0] op, input bit expect_go);
    cmd_opcode = op;
    @(negedge clk);
    if (expect_go) exp_q.push_back(op);
    wr_reg(8'h80);
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 60; i++) begin
      if (reg_rdata[6]) break;
      @(negedge clk);
    end
    check(req, reg_rdata & 8'hC0, 8'hC0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00; cmd_opcode = OP_PLAIN;
    seq_ok = 1'b1; div_ready = 1'b1; tgt_prot = 1'b0; stop_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 reset value", reg_rdata, 8'hC0);
    wr_reg(8'h0F);
    check("R1 reserved bits", reg_rdata, 8'hC0);
    wr_reg(8'h40);
    check("R3 write to complete", reg_rdata, 8'hC0);

    // R2 plain launch timing
    launch(OP_PLAIN, 1);
    check("R2 after launch", reg_rdata, 8'h00);
    @(negedge clk);
    check("R2 start pulse", {7'd0, arr_start}, 8'h01);
    check("R2 empty after transfer", reg_rdata, 8'h80);
    wait_idle("R3 complete returns");

    // R12 second launch while buffer full
    launch(OP_PLAIN, 1);
    cmd_opcode = 8'h55;
    wr_reg(8'h80);
    check("R12 ignored launch", reg_rdata, 8'h80);
    wait_idle("R12 idle");
    check("R12 no error", reg_rdata, 8'hC0);

    // R4 burst queued behind burst
    launch(OP_BURST, 1);
    @(negedge clk);
    exp_q.push_back(OP_BURST);
    wr_reg(8'h80);
    check("R4 queued burst", reg_rdata, 8'h00);
    for (int i = 0; i < 30; i++) begin
      if (arr_done) break;
      @(negedge clk);
    end
    @(negedge clk);
    check("R4 back-to-back start", {7'd0, arr_start}, 8'h01);
    wait_idle("R4 idle");

    // R5 plain command while burst runs
    launch(OP_BURST, 1);
    @(negedge clk);
    launch(OP_PLAIN, 0);
    check("R5 ordering error", reg_rdata, 8'h90);
    wait_idle("R5 idle");
    wr_reg(8'h00);
    check("R10 write zero keeps", reg_rdata, 8'hD0);
    wr_reg(8'h10);
    check("R10 clear access error", reg_rdata, 8'hC0);

    // R6 bad sequence
    seq_ok = 1'b0;
    launch(OP_PLAIN, 0);
    check("R6 sequence error", reg_rdata, 8'hD0);
    seq_ok = 1'b1;
    wr_reg(8'h10);

    // R7 divider not ready, then R11 clear plus launch
    div_ready = 1'b0;
    launch(OP_PLAIN, 0);
    check("R7 divider error", reg_rdata, 8'hD0);
    div_ready = 1'b1;
    cmd_opcode = OP_PLAIN;
    @(negedge clk);
    exp_q.push_back(OP_PLAIN);
    wr_reg(8'h90);
    check("R11 clear and launch", reg_rdata, 8'h00);
    wait_idle("R11 idle");

    // R8 protection
    tgt_prot = 1'b1;
    launch(OP_PLAIN, 0);
    check("R8 protection", reg_rdata, 8'hE0);
    tgt_prot = 1'b0;
    launch(OP_PLAIN, 0);
    check("R11 launch blocked by error", reg_rdata, 8'hE0);
    tgt_prot = 1'b1;
    seq_ok = 1'b0;
    @(negedge clk);
    wr_reg(8'hA0);
    check("R8 access priority", reg_rdata, 8'hD0);
    tgt_prot = 1'b0;
    seq_ok = 1'b1;
    wr_reg(8'h10);
    check("R10 clear", reg_rdata, 8'hC0);

    // R9 stop while executing
    launch(OP_PLAIN, 1);
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R9 stop status", reg_rdata, 8'hD0);
    check("R9 abort pulse", {7'd0, arr_abort}, 8'h01);
    wr_reg(8'h10);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R9 idle stop", reg_rdata, 8'hC0);

    repeat (10) @(negedge clk);
    check("R2 all starts seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule